// File: doc/BRIEF.md
# E1 Spare-Bit Clock Quality Nibble Extractor

This block sits on the receive side of an E1 framer. It looks at the timeslot-0 byte of every frame, takes one spare national bit position chosen by a three-bit lane selector, and builds four-bit clock quality codes from those bits. Frame alignment is done elsewhere. The framer gives the block a byte strobe, the frame index within the sixteen-frame multiframe and a flag that says the multiframe is locked.

Only odd frames carry spare bits. A multiframe therefore yields two nibbles, and each one starts at frame 1 or frame 9 so that its bit order is never in doubt. The first bit received is the most significant. A new code reaches the output only after the same nibble has arrived in three nibble periods in a row. When that happens a one-cycle change pulse is raised. The codes keep the meaning of the synchronization quality field of the SDH S1 byte, and the block passes them through unaltered.

Top module: `e1_ssm_extract`

## Requirements
- R1: After reset `ssmValid` and `ssmChange` are 0 and `ssmCode` is 4'h0.
- R2: Selector values 0, 1, 2, 3 and 4 pick timeslot-0 byte bits `tsByte[4]`, `[3]`, `[2]`, `[1]` and `[0]`. These are the spare bits Sa4 to Sa8, with `tsByte[7]` being the first bit on the line. The other bits of the byte have no effect.
- R3: Selector values 5, 6 and 7 disable the block. While such a value is applied, `ssmValid` is 0 from the next cycle on and `ssmChange` never pulses.
- R4: Bytes strobed with an even frame index (`frameNum[0]`=0) contribute no bits.
- R5: Frames 1, 3, 5 and 7 carry bits 3 down to 0 of one nibble, and frames 9, 11, 13 and 15 carry bits 3 down to 0 of the next. The bit from frame 1 or 9 is the MSB. If any bit of a nibble is missing, that nibble is discarded.
- R6: When the same nibble has been completed in three consecutive nibble periods and it differs from the current output, or the output is not valid, the block acts on the clock edge that samples the strobe of the last bit. On that edge `ssmCode` takes the nibble, `ssmValid` goes to 1 and `ssmChange` is 1 for that one cycle.
- R7: A nibble that is received only once or twice in a row never reaches `ssmCode`.
- R8: A cycle with `mfLocked`=0 clears `ssmValid` on the next edge and drops any partial nibble and any repeat count. `ssmCode` keeps its value.
- R9: A change of `laneSel` clears `ssmValid` on the next edge and restarts assembly in the same way as R8.
- R10: `ssmCode` changes only in a cycle where `ssmChange` is 1. `ssmChange` never stays high for two cycles in a row, and `ssmValid` only rises together with it.
- R11: All sixteen code values pass through bit for bit on every lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tsByte | input | 8 | Timeslot-0 byte; `tsByte[7]` is the first bit on the line |
| tsStrobe | input | 1 | One-cycle strobe for `tsByte` |
| frameNum | input | 4 | Frame index 0 to 15 within the multiframe |
| mfLocked | input | 1 | Multiframe alignment is locked |
| laneSel | input | 3 | Spare bit lane: 0 to 4 select Sa4 to Sa8, 5 to 7 disable |
| ssmCode | output | 4 | Confirmed quality code |
| ssmValid | output | 1 | `ssmCode` is confirmed under the current lane and lock |
| ssmChange | output | 1 | One-cycle pulse when `ssmCode` is loaded |

## Verification
Every result is registered once. Code, valid and the change pulse take their new values on the rising edge that samples the strobe of the frame carrying the last bit of the confirming nibble, which is frame 7 or frame 15. Loss of lock and a selector change clear valid on the first rising edge that sees them. The bench drives every input on a falling edge and reads the outputs on the following falling edge, one half period after the edge that is due. It reads the change pulse for frames 7 and 15 at that point, before the next edge clears it.

// File: rtl/e1ssm_pkg.sv
package e1ssm_pkg;
  // Strobes issued by the control path to the datapath each cycle
  typedef struct packed {
    logic clear;     // restart: drop partial nibble, repeat count and valid
    logic takeBit;   // shift the selected lane bit in
    logic firstBit;  // the bit taken is the MSB of a new nibble
    logic nibDone;   // the bit taken completes a nibble
  } ssmCtrl_t;
endpackage

// File: rtl/e1ssm_ctrl.sv
module e1ssm_ctrl
  import e1ssm_pkg::*;
#(
  parameter int FRAME_W  = 4,
  parameter int SEL_W    = 3,
  parameter int NIB_W    = 4,
  parameter int SA_LANES = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tsStrobe,
  input  logic [FRAME_W-1:0] frameNum,
  input  logic               mfLocked,
  input  logic [SEL_W-1:0]   laneSel,
  output ssmCtrl_t           ctrl
);
  localparam int POS_W = $clog2(NIB_W);
  localparam int CNT_W = POS_W + 1;

  logic [SEL_W-1:0] selQ;
  logic [CNT_W-1:0] bitCnt, cntNext;
  logic [POS_W-1:0] pos;
  logic             laneOn, restart, oddFrame;
  logic             unusedFrameHi;

  // odd frames carry spare bits; bits [POS_W:1] give the place in the nibble
  assign oddFrame      = frameNum[0];
  assign pos           = frameNum[POS_W:1];
  assign unusedFrameHi = ^frameNum[FRAME_W-1:POS_W+1];
  assign laneOn        = (laneSel < SEL_W'(SA_LANES));
  assign restart       = !mfLocked || !laneOn || (laneSel != selQ);

  always_comb begin
    ctrl       = '0;
    ctrl.clear = restart;
    cntNext    = bitCnt;
    if (restart) begin
      cntNext = '0;
    end else if (tsStrobe && oddFrame) begin
      if (pos == '0) begin
        ctrl.takeBit  = 1'b1;
        ctrl.firstBit = 1'b1;
        cntNext       = CNT_W'(1);
      end else if ({1'b0, pos} == bitCnt) begin
        ctrl.takeBit = 1'b1;
        if (pos == POS_W'(NIB_W - 1)) begin
          ctrl.nibDone = 1'b1;
          cntNext      = '0;
        end else begin
          cntNext = bitCnt + CNT_W'(1);
        end
      end else begin
        // a bit of this nibble went missing: drop it
        cntNext = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ   <= '0;
      bitCnt <= '0;
    end else begin
      selQ   <= laneSel;
      bitCnt <= cntNext;
    end
  end
endmodule

// File: rtl/e1ssm_datapath.sv
module e1ssm_datapath
  import e1ssm_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int SEL_W    = 3,
  parameter int NIB_W    = 4,
  parameter int SA_LANES = 5,
  parameter int CONFIRM  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] tsByte,
  input  logic [SEL_W-1:0]  laneSel,
  input  ssmCtrl_t          ctrl,
  output logic [NIB_W-1:0]  ssmCode,
  output logic              ssmValid,
  output logic              ssmChange
);
  localparam int HIT_W = $clog2(CONFIRM + 1);

  logic             laneBit;
  logic [NIB_W-2:0] shiftQ;
  logic [NIB_W-1:0] nibble, candQ;
  logic [HIT_W-1:0] hitQ, hitNext;
  logic             sameCand;
  logic             unusedByteHi;

  assign unusedByteHi = ^tsByte[BYTE_W-1:SA_LANES];

  // lane 0 is the highest spare position, lane SA_LANES-1 the lowest
  always_comb begin
    laneBit = 1'b0;
    for (int i = 0; i < SA_LANES; i++) begin
      if (laneSel == SEL_W'(i)) laneBit = tsByte[SA_LANES-1-i];
    end
  end

  assign nibble   = {shiftQ, laneBit};
  assign sameCand = (hitQ != '0) && (nibble == candQ);

  always_comb begin
    if (sameCand) hitNext = (hitQ == HIT_W'(CONFIRM)) ? hitQ : hitQ + HIT_W'(1);
    else          hitNext = HIT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ    <= '0;
      candQ     <= '0;
      hitQ      <= '0;
      ssmCode   <= '0;
      ssmValid  <= 1'b0;
      ssmChange <= 1'b0;
    end else begin
      ssmChange <= 1'b0;
      if (ctrl.clear) begin
        hitQ     <= '0;
        ssmValid <= 1'b0;
      end else if (ctrl.takeBit) begin
        if (ctrl.firstBit) shiftQ <= (NIB_W-1)'(laneBit);
        else               shiftQ <= {shiftQ[NIB_W-3:0], laneBit};
        if (ctrl.nibDone) begin
          candQ <= nibble;
          hitQ  <= hitNext;
          if (hitNext == HIT_W'(CONFIRM) && (!ssmValid || ssmCode != nibble)) begin
            ssmCode   <= nibble;
            ssmValid  <= 1'b1;
            ssmChange <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/e1_ssm_extract.sv
module e1_ssm_extract
  import e1ssm_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int FRAME_W  = 4,
  parameter int SEL_W    = 3,
  parameter int NIB_W    = 4,
  parameter int SA_LANES = 5,
  parameter int CONFIRM  = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [BYTE_W-1:0]  tsByte,
  input  logic               tsStrobe,
  input  logic [FRAME_W-1:0] frameNum,
  input  logic               mfLocked,
  input  logic [SEL_W-1:0]   laneSel,
  output logic [NIB_W-1:0]   ssmCode,
  output logic               ssmValid,
  output logic               ssmChange
);
  ssmCtrl_t ctrl;

  e1ssm_ctrl #(
    .FRAME_W(FRAME_W), .SEL_W(SEL_W), .NIB_W(NIB_W), .SA_LANES(SA_LANES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .tsStrobe(tsStrobe), .frameNum(frameNum),
    .mfLocked(mfLocked), .laneSel(laneSel), .ctrl(ctrl)
  );

  e1ssm_datapath #(
    .BYTE_W(BYTE_W), .SEL_W(SEL_W), .NIB_W(NIB_W),
    .SA_LANES(SA_LANES), .CONFIRM(CONFIRM)
  ) u_dp (
    .clk(clk), .rstN(rstN), .tsByte(tsByte), .laneSel(laneSel), .ctrl(ctrl),
    .ssmCode(ssmCode), .ssmValid(ssmValid), .ssmChange(ssmChange)
  );
endmodule

// File: rtl/e1ssm_checker.sv
module e1ssm_checker #(
  parameter int SEL_W    = 3,
  parameter int NIB_W    = 4,
  parameter int SA_LANES = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic [SEL_W-1:0] laneSel,
  input logic             mfLocked,
  input logic [NIB_W-1:0] ssmCode,
  input logic             ssmValid,
  input logic             ssmChange
);
  p_off_lane_r3: assert property (@(posedge clk) disable iff (!rstN)
    (laneSel >= SEL_W'(SA_LANES)) |=> !ssmValid);

  p_change_valid_r6: assert property (@(posedge clk) disable iff (!rstN)
    ssmChange |-> ssmValid);

  p_unlock_r8: assert property (@(posedge clk) disable iff (!rstN)
    !mfLocked |=> !ssmValid);

  p_sel_move_r9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(laneSel) |=> !ssmValid);

  p_code_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !ssmChange |-> $stable(ssmCode));

  p_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    ssmChange |=> !ssmChange);

  p_valid_rise_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ssmValid) |-> ssmChange);
endmodule

bind e1_ssm_extract e1ssm_checker #(
  .SEL_W(SEL_W), .NIB_W(NIB_W), .SA_LANES(SA_LANES)
) u_chk (
  .clk(clk), .rstN(rstN), .laneSel(laneSel), .mfLocked(mfLocked),
  .ssmCode(ssmCode), .ssmValid(ssmValid), .ssmChange(ssmChange)
);

// File: tb/e1_ssm_extract_bench.sv
module e1_ssm_extract_bench;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] tsByte = '0;
  logic       tsStrobe = 1'b0;
  logic [3:0] frameNum = '0;
  logic       mfLocked = 1'b1;
  logic [2:0] laneSel = '0;
  logic [3:0] ssmCode;
  logic       ssmValid, ssmChange;

  int  checks = 0;
  int  fails = 0;
  bit  done = 0;
  logic chA, chB;

  always #(CLK_PERIOD/2) clk = ~clk;

  e1_ssm_extract u_e1_ssm_extract (
    .clk(clk), .rstN(rstN), .tsByte(tsByte), .tsStrobe(tsStrobe),
    .frameNum(frameNum), .mfLocked(mfLocked), .laneSel(laneSel),
    .ssmCode(ssmCode), .ssmValid(ssmValid), .ssmChange(ssmChange)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkEq(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  // lane bit placed at tsByte[4-sel]; every other bit is its inverse
  function automatic logic [7:0] mkByte(input int sel, input logic b, input int f);
    logic [7:0] r;
    if (f % 2 == 0) return (f % 4 == 0) ? 8'hA5 : 8'h5A;
    r = {8{~b}};
    if (sel < 5) r[4-sel] = b;
    return r;
  endfunction

  task automatic sendByte(input int f, input logic [7:0] b);
    @(negedge clk);
    frameNum = 4'(f);
    tsByte   = b;
    tsStrobe = 1'b1;
    @(negedge clk);
    tsStrobe = 1'b0;
  endtask

  // one multiframe; skip[f]=1 leaves frame f out; records the change pulse after frames 7 and 15
  task automatic sendMf(input int sel, input logic [3:0] nA, input logic [3:0] nB,
                        input logic [15:0] skip);
    chA = 1'b0;
    chB = 1'b0;
    for (int f = 0; f < 16; f++) begin
      logic [3:0] nib;
      logic       bv;
      if (!skip[f]) begin
        nib = (f < 8) ? nA : nB;
        bv  = nib[3 - ((f >> 1) & 3)];
        sendByte(f, mkByte(sel, bv, f));
        if (f == 7)  chA = ssmChange;
        if (f == 15) chB = ssmChange;
      end
    end
  endtask

  task automatic setSel(input int s);
    @(negedge clk);
    laneSel = 3'(s);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [3:0] held;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    checkEq("R1 valid", ssmValid, 0);
    checkEq("R1 change", ssmChange, 0);
    checkEq("R1 code", ssmCode, 0);

    // R2 R4 R6 R7 R11 sweep: every lane, every code, MSB first
    for (int s = 0; s < 5; s++) begin
      if (s != 0) begin
        setSel(s);
        checkEq("R9 valid after lane change", ssmValid, 0);
      end
      for (int v = 0; v < 16; v++) begin
        sendMf(s, 4'(v), 4'(v), 16'h0);
        checkEq("R7 no change on two repeats A", chA, 0);
        checkEq("R7 no change on two repeats B", chB, 0);
        sendMf(s, 4'(v), 4'(v), 16'h0);
        checkEq("R6 change on third repeat", chA, 1);
        checkEq("R11 R2 code on lane", ssmCode, v);
        checkEq("R6 valid", ssmValid, 1);
        checkEq("R10 single pulse", chB, 0);
      end
    end

    // R3 disabled lanes
    for (int s = 5; s < 8; s++) begin
      setSel(s);
      checkEq("R3 valid off", ssmValid, 0);
      for (int k = 0; k < 2; k++) begin
        sendMf(0, 4'h9, 4'h9, 16'h0);
        checkEq("R3 no change A", chA, 0);
        checkEq("R3 no change B", chB, 0);
      end
      checkEq("R3 valid stays off", ssmValid, 0);
    end

    // R7 single glitch does not move the output
    setSel(2);
    sendMf(2, 4'h6, 4'h6, 16'h0);
    sendMf(2, 4'h6, 4'h6, 16'h0);
    checkEq("R6 lane2 confirm", chA, 1);
    sendMf(2, 4'h6, 4'hB, 16'h0);
    sendMf(2, 4'h6, 4'h6, 16'h0);
    checkEq("R7 glitch ignored code", ssmCode, 6);
    checkEq("R7 glitch no pulse", chA | chB, 0);
    sendMf(2, 4'hB, 4'hB, 16'h0);
    sendMf(2, 4'hB, 4'h6, 16'h0);
    checkEq("R7 new code after three", chA, 1);
    checkEq("R7 new code value", ssmCode, 11);

    // R8 loss of lock
    held = ssmCode;
    @(negedge clk);
    mfLocked = 1'b0;
    @(negedge clk);
    mfLocked = 1'b1;
    checkEq("R8 valid cleared", ssmValid, 0);
    checkEq("R8 code held", ssmCode, held);
    sendMf(2, 4'hC, 4'hC, 16'h0);
    checkEq("R8 restart no early confirm", chA | chB, 0);
    sendMf(2, 4'hC, 4'hC, 16'h0);
    checkEq("R8 reacquire", chA, 1);
    checkEq("R8 reacquired code", ssmCode, 12);

    // R5 missing frame 1 discards the first nibble
    setSel(1);
    sendMf(1, 4'h5, 4'hA, 16'h0002);
    checkEq("R5 partial nibble not counted", chA | chB, 0);
    sendMf(1, 4'hA, 4'hA, 16'h0);
    checkEq("R5 no confirm on second", chA, 0);
    checkEq("R5 confirm on third", chB, 1);
    checkEq("R5 code", ssmCode, 10);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule